// File: doc/BRIEF.md
# PCI Interrupt Pin Router

This block steers the four level-sensitive PCI interrupt pins (A, B, C and D) onto sixteen ISA-style interrupt request lines that feed a legacy interrupt controller. Three byte-wide routing registers hold one 4-bit target code per pin. A simple strobed register port writes and reads them. Code 0 disables a pin. Any other code names the ISA line that the pin drives.

Several pins may share one target. The line is then the OR of their levels. Codes 2, 8 and 13 are reserved. A pin routed to one of them still passes its level to that line, but it also raises a sticky misconfiguration flag. A dedicated clear input drops the flag.

The line outputs are combinational in the pin levels and the stored codes. A pin edge therefore reaches the interrupt controller in the same cycle. A register write takes effect right after the edge that stores it.

Top module: `pirq_router`

## Requirements
- R1: During and after reset, and until the first write, all three routing registers read 0x00, all of `isa_irq` is low and `route_err` is low.
- R2: Writes to addresses 0x55, 0x56 and 0x57 store the whole byte. When `reg_re` is high at an edge, `reg_rdata` shows that register (or 0x00 for any other address) after that edge, and it holds its value while `reg_re` is low. A write to any other address changes nothing.
- R3: The target codes sit at these positions: pin A in 0x55 bits [7:4], pin B in 0x56 bits [3:0], pin C in 0x56 bits [7:4], pin D in 0x57 bits [7:4]. `pin_lvl` bit 0 is pin A, bit 1 is B, bit 2 is C and bit 3 is D.
- R4: A pin whose code is 0 drives no line, and `isa_irq[0]` is always low.
- R5: For n = 1..15, `isa_irq[n]` is the OR of the levels of all pins whose code equals n, and it follows `pin_lvl` in the same cycle.
- R6: Bits [3:0] of 0x55 and bits [3:0] of 0x57 affect neither `isa_irq` nor `route_err`.
- R7: If any pin's code is 2, 8 or 13 at an edge, `route_err` is high after that edge, and the pin's level still reaches the named line.
- R8: `route_err` stays high until an edge where `err_clr` is high and no pin holds a reserved code. If a reserved code is still present, the set wins over the clear.
- R9: A write changes `isa_irq` from the edge that stores it, with no further delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_lvl | input | 4 | PCI interrupt pin levels, bit 0 = A … bit 3 = D |
| reg_addr | input | 8 | Register port address |
| reg_wdata | input | 8 | Register write data |
| reg_we | input | 1 | Write strobe |
| reg_re | input | 1 | Read strobe |
| reg_rdata | output | 8 | Registered read data |
| err_clr | input | 1 | Clears the misconfiguration flag |
| isa_irq | output | 16 | ISA interrupt request lines |
| route_err | output | 1 | Sticky reserved-target flag |

## Verification
The results of this block are due at different times.
- `isa_irq` depends on `pin_lvl` with zero latency. The bench changes the pins at a falling edge and samples one time step later, inside the same cycle.
- A register write reaches `isa_irq`, and a read strobe reaches `reg_rdata`, one rising edge later. The bench samples these at the falling edge after the strobe.
- `route_err` registers the state of the codes at each edge. It is checked at the falling edge after a single-cycle clear pulse, so the value read reflects the settled configuration.

Every pin is swept through all sixteen codes, and each code is checked against all sixteen pin patterns.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
    localparam int PIN_NUM  = 4;
    localparam int LINE_NUM = 16;
    localparam int TGT_W    = 4;
    localparam int ADDR_W   = 8;
    localparam int DATA_W   = 8;
    localparam int TGT_BUS_W = PIN_NUM * TGT_W;

    localparam logic [ADDR_W-1:0] ROUTE0_OFF = 8'h55;
    localparam logic [ADDR_W-1:0] ROUTE1_OFF = 8'h56;
    localparam logic [ADDR_W-1:0] ROUTE2_OFF = 8'h57;

    typedef enum logic [1:0] {
        SEL_ROUTE0,
        SEL_ROUTE1,
        SEL_ROUTE2,
        SEL_NONE
    } reg_sel_e;

    function automatic logic code_reserved(input logic [TGT_W-1:0] code);
        return (code == TGT_W'(2)) || (code == TGT_W'(8)) || (code == TGT_W'(13));
    endfunction
endpackage

// File: rtl/pirq_cfg_regs.sv
module pirq_cfg_regs
    import pirq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DATA_W-1:0]    wdata,
    input  logic                 we,
    input  logic                 re,
    output logic [DATA_W-1:0]    rdata,
    output logic [TGT_BUS_W-1:0] tgt_bus
);
    localparam int HI = DATA_W - 1;
    localparam int LO_TOP = TGT_W - 1;

    logic [DATA_W-1:0] route0_q, route1_q, route2_q;
    reg_sel_e          sel;

    always_comb begin
        unique case (addr)
            ROUTE0_OFF: sel = SEL_ROUTE0;
            ROUTE1_OFF: sel = SEL_ROUTE1;
            ROUTE2_OFF: sel = SEL_ROUTE2;
            default:    sel = SEL_NONE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            route0_q <= '0;
            route1_q <= '0;
            route2_q <= '0;
        end else if (we) begin
            unique case (sel)
                SEL_ROUTE0: route0_q <= wdata;
                SEL_ROUTE1: route1_q <= wdata;
                SEL_ROUTE2: route2_q <= wdata;
                SEL_NONE:   ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (re) begin
            unique case (sel)
                SEL_ROUTE0: rdata <= route0_q;
                SEL_ROUTE1: rdata <= route1_q;
                SEL_ROUTE2: rdata <= route2_q;
                SEL_NONE:   rdata <= '0;
            endcase
        end
    end

    // Field placement is fixed: downstream decode depends on it.
    assign tgt_bus = { route2_q[HI -: TGT_W],     // pin D
                       route1_q[HI -: TGT_W],     // pin C
                       route1_q[LO_TOP:0],        // pin B
                       route0_q[HI -: TGT_W] };   // pin A
endmodule

// File: rtl/pirq_line_merge.sv
module pirq_line_merge
    import pirq_pkg::*;
#(
    parameter int N_PINS  = PIN_NUM,
    parameter int N_LINES = LINE_NUM,
    parameter int CODE_W  = TGT_W
) (
    input  logic [N_PINS*CODE_W-1:0] tgt_bus,
    input  logic [N_PINS-1:0]        pin_lvl,
    output logic [N_LINES-1:0]       lines
);
    assign lines[0] = 1'b0;

    for (genvar gl = 1; gl < N_LINES; gl++) begin : g_line
        logic hit;
        always_comb begin
            hit = 1'b0;
            for (int p = 0; p < N_PINS; p++) begin
                if (tgt_bus[p*CODE_W +: CODE_W] == CODE_W'(gl)) begin
                    hit = hit | pin_lvl[p];
                end
            end
        end
        assign lines[gl] = hit;
    end
endmodule

// File: rtl/pirq_err_track.sv
module pirq_err_track
    import pirq_pkg::*;
#(
    parameter int N_PINS = PIN_NUM,
    parameter int CODE_W = TGT_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N_PINS*CODE_W-1:0] tgt_bus,
    input  logic                     clr,
    output logic                     err
);
    logic [N_PINS-1:0] res_hit;

    for (genvar gp = 0; gp < N_PINS; gp++) begin : g_pin
        assign res_hit[gp] = code_reserved(TGT_W'(tgt_bus[gp*CODE_W +: CODE_W]));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err <= 1'b0;
        end else begin
            err <= (err & ~clr) | (|res_hit);
        end
    end
endmodule

// File: rtl/pirq_router.sv
module pirq_router
    import pirq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [PIN_NUM-1:0]  pin_lvl,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    input  logic                reg_we,
    input  logic                reg_re,
    output logic [DATA_W-1:0]   reg_rdata,
    input  logic                err_clr,
    output logic [LINE_NUM-1:0] isa_irq,
    output logic                route_err
);
    logic [TGT_BUS_W-1:0] tgt_bus;

    pirq_cfg_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .we      (reg_we),
        .re      (reg_re),
        .rdata   (reg_rdata),
        .tgt_bus (tgt_bus)
    );

    pirq_line_merge #(
        .N_PINS  (PIN_NUM),
        .N_LINES (LINE_NUM),
        .CODE_W  (TGT_W)
    ) u_merge (
        .tgt_bus (tgt_bus),
        .pin_lvl (pin_lvl),
        .lines   (isa_irq)
    );

    pirq_err_track #(
        .N_PINS (PIN_NUM),
        .CODE_W (TGT_W)
    ) u_err (
        .clk     (clk),
        .rst_n   (rst_n),
        .tgt_bus (tgt_bus),
        .clr     (err_clr),
        .err     (route_err)
    );
endmodule

// File: rtl/pirq_router_chk.sv
module pirq_router_chk
    import pirq_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic [PIN_NUM-1:0]   pin_lvl,
    input logic                 reg_re,
    input logic [DATA_W-1:0]    reg_rdata,
    input logic                 err_clr,
    input logic [LINE_NUM-1:0]  isa_irq,
    input logic                 route_err,
    input logic [TGT_BUS_W-1:0] tgt_bus
);
    logic any_res;
    always_comb begin
        any_res = 1'b0;
        for (int p = 0; p < PIN_NUM; p++) begin
            if (code_reserved(tgt_bus[p*TGT_W +: TGT_W])) any_res = 1'b1;
        end
    end

    AST_QUIET_PINS: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_lvl == '0) |-> (isa_irq == '0)); // R5
    AST_LINES_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(isa_irq) <= $countones(pin_lvl))); // R5
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (route_err && !err_clr) |=> route_err); // R8
    AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(route_err) |-> $past(any_res)); // R7
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_re |=> $stable(reg_rdata)); // R2
endmodule

bind pirq_router pirq_router_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_lvl   (pin_lvl),
    .reg_re    (reg_re),
    .reg_rdata (reg_rdata),
    .err_clr   (err_clr),
    .isa_irq   (isa_irq),
    .route_err (route_err),
    .tgt_bus   (tgt_bus)
);

// File: tb/pirq_router_bench.sv
module pirq_router_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  pin_lvl = '0;
    logic [7:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic        reg_we = 1'b0;
    logic        reg_re = 1'b0;
    logic [7:0]  reg_rdata;
    logic        err_clr = 1'b0;
    logic [15:0] isa_irq;
    logic        route_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    pirq_router u_pirq_router (
        .clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_re(reg_re),
        .reg_rdata(reg_rdata), .err_clr(err_clr), .isa_irq(isa_irq),
        .route_err(route_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_re = 1'b1;
        @(negedge clk);
        reg_re = 1'b0;
        d = reg_rdata;
    endtask

    task automatic pulse_clr();
        @(negedge clk);
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
    endtask

    function automatic logic [15:0] model(input logic [3:0] ta, input logic [3:0] tb,
                                          input logic [3:0] tc, input logic [3:0] td,
                                          input logic [3:0] lvl);
        logic [15:0] r = '0;
        logic [3:0]  t [4];
        t[0] = ta; t[1] = tb; t[2] = tc; t[3] = td;
        for (int i = 0; i < 4; i++) if (t[i] != 0 && lvl[i]) r[t[i]] = 1'b1;
        return r;
    endfunction

    function automatic logic is_res(input logic [3:0] c);
        return c == 4'd2 || c == 4'd8 || c == 4'd13;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic [3:0] ta, tb, tc, td;
        repeat (3) @(negedge clk);
        pin_lvl = 4'hF;
        #1;
        chk("R1 lines in reset", {16'h0, isa_irq}, 32'h0);
        chk("R1 err in reset", {31'h0, route_err}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 lines after reset", {16'h0, isa_irq}, 32'h0);
        rd(8'h55, d); chk("R1 reg 0x55", {24'h0, d}, 32'h0);
        rd(8'h56, d); chk("R1 reg 0x56", {24'h0, d}, 32'h0);
        rd(8'h57, d); chk("R1 reg 0x57", {24'h0, d}, 32'h0);

        // R2 read-back and unmapped address
        wr(8'h55, 8'hA7); wr(8'h56, 8'h3C); wr(8'h57, 8'h91);
        rd(8'h55, d); chk("R2 readback 0x55", {24'h0, d}, 32'hA7);
        rd(8'h56, d); chk("R2 readback 0x56", {24'h0, d}, 32'h3C);
        rd(8'h57, d); chk("R2 readback 0x57", {24'h0, d}, 32'h91);
        @(negedge clk); chk("R2 rdata holds", {24'h0, reg_rdata}, 32'h91);
        wr(8'h54, 8'hFF); wr(8'h58, 8'hFF);
        rd(8'h54, d); chk("R2 unmapped reads zero", {24'h0, d}, 32'h0);
        rd(8'h55, d); chk("R2 unmapped write ignored", {24'h0, d}, 32'hA7);
        rd(8'h56, d); chk("R2 unmapped write ignored", {24'h0, d}, 32'h3C);

        // Exhaustive sweep: every pin, every code, every pin pattern
        for (int p = 0; p < 4; p++) begin
            for (int t = 0; t < 16; t++) begin
                ta = (p == 0) ? 4'(t) : 4'h0;
                tb = (p == 1) ? 4'(t) : 4'h0;
                tc = (p == 2) ? 4'(t) : 4'h0;
                td = (p == 3) ? 4'(t) : 4'h0;
                pin_lvl = 4'hF;
                // Unused low nibbles carry reserved-looking junk (R6)
                wr(8'h55, {ta, 4'hD});
                wr(8'h56, {tc, tb});
                wr(8'h57, {td, 4'h8});
                #1;
                chk("R9 route live after write edge", {16'h0, isa_irq},
                    {16'h0, model(ta, tb, tc, td, 4'hF)});
                pulse_clr();
                chk("R7 R6 R8 err after clear", {31'h0, route_err}, {31'h0, is_res(4'(t))});
                for (int l = 0; l < 16; l++) begin
                    pin_lvl = 4'(l);
                    #1;
                    chk("R3 R4 R5 line map", {16'h0, isa_irq},
                        {16'h0, model(ta, tb, tc, td, 4'(l))});
                    #1;
                end
            end
        end

        // R5 shared target: all pins on line 5, then split
        wr(8'h55, 8'h50); wr(8'h56, 8'h55); wr(8'h57, 8'h50);
        for (int l = 0; l < 16; l++) begin
            pin_lvl = 4'(l);
            #1;
            chk("R5 shared OR", {16'h0, isa_irq}, (l != 0) ? 32'h20 : 32'h0);
        end
        wr(8'h57, 8'hF0);
        pin_lvl = 4'b1000;
        #1;
        chk("R5 line drops when unmapped", {16'h0, isa_irq}, 32'h8000);

        // R8 stickiness and set-wins-over-clear
        wr(8'h56, 8'h8E);
        pin_lvl = 4'b0100;
        #1;
        chk("R7 reserved level passes", {16'h0, isa_irq}, 32'h0100);
        @(negedge clk);
        chk("R7 err set", {31'h0, route_err}, 32'h1);
        pulse_clr();
        chk("R8 set wins over clear", {31'h0, route_err}, 32'h1);
        wr(8'h56, 8'h1E);
        repeat (3) @(negedge clk);
        chk("R8 sticky without clear", {31'h0, route_err}, 32'h1);
        pulse_clr();
        chk("R8 clear drops flag", {31'h0, route_err}, 32'h0);
        pin_lvl = 4'h0;
        #1;
        chk("R4 line0 low", {31'h0, isa_irq[0]}, 32'h0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule